// File: doc/BRIEF.md
# Associative Name Search Comparator

This block lets software search a running display list for entities tagged with a particular label. Software writes a control word that holds a search name and a search mode. Whenever the display engine executes a name instruction, it presents an 11-bit label for one cycle together with a valid strobe. The block then compares that label with the stored search name over all 11 bits, over the upper 8 bits only, or over the upper 4 bits only, depending on the mode.

When a label matches, the block raises a sticky match flag, drives it on an interrupt output, and keeps the matching label so that software can read which entity was hit. A single-cycle clear pulse drops the flag. The engine issues this pulse whenever it is started, resumed or power-cleared.

The control word has separate update enables for the name field and the mode field. One write can therefore change either field without disturbing the other. The read side is a 16-bit word that carries the flag, the active mode and the captured label.

Top module: `assoc_name_search`

## Requirements
- R1: After reset, `name_rdata` reads 16'h0000 and `match_irq` is low. The search mode is 00 and the stored search name is 0.
- R2: A write with `ctl_wdata[11]`=1 loads `ctl_wdata[10:0]` as the search name. A write with bit 11 = 0 leaves the search name unchanged.
- R3: A write with `ctl_wdata[14]`=1 loads `ctl_wdata[13:12]` as the search mode, which reads back in `name_rdata[13:12]`. With bit 14 = 0 the mode is unchanged. Write bit 15 has no effect. `name_rdata[14]` and `name_rdata[11]` always read 0.
- R4: Under mode 00, no label ever produces a match.
- R5: Under mode 01, a label matches only when all 11 bits equal the search name.
- R6: Under mode 10, a label matches when bits 10..3 equal those of the search name; bits 2..0 are ignored.
- R7: Under mode 11, a label matches when bits 10..7 equal those of the search name; bits 6..0 are ignored.
- R8: A match in the cycle where `name_vld` is high sets the flag on the next clock edge. From that edge, `name_rdata[15]`=1, `match_irq`=1, and `name_rdata[10:0]` holds the matching label.
- R9: Once set, the flag stays set until a cycle with `flag_clr` high. On the following edge, the flag and `match_irq` drop and the captured label is kept.
- R10: A later match while the flag is set replaces the captured label with the newer one. A non-matching strobe changes neither the flag nor the label.
- R11: A label is compared only in a cycle where `name_vld` is high. A matching label with the strobe low has no effect.
- R12: When a control write and a strobe occur in the same cycle, the comparison uses the search name and mode held before that write.
- R13: A match in the same cycle as `flag_clr` leaves the flag set and captures that label.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data: name [10:0], name enable [11], mode [13:12], mode enable [14] |
| name_vld | input | 1 | Name instruction strobe, one cycle per label |
| name_label | input | 11 | Label from the current name instruction |
| flag_clr | input | 1 | Clear pulse for the match flag (start, resume, power clear) |
| name_rdata | output | 16 | Read word: flag [15], mode [13:12], captured label [10:0] |
| match_irq | output | 1 | Interrupt request, high while the match flag is set |

## Verification
The bench places labels one bit either side of each mode's compare boundary. A design with a wrong mask width would match a label that differs in bit 3 under mode 10, or in bit 7 under mode 11, or it would reject one that differs only in the ignored bits.

It writes control words with one enable clear and checks that the other field is untouched. A design that ignores the enables would silently change the name or the mode.

It also stacks events in a single cycle, and each stack exposes a specific fault:
- A write together with a strobe: a design that compares against the just-written name misses the match.
- A clear together with a match: a design that gives the clear priority loses the event.
- A second match while the flag is set: a design that freezes the first label returns stale data.

// File: rtl/anm_pkg.sv
`timescale 1ns/1ps
package anm_pkg;

  typedef enum logic [1:0] {
    SRCH_OFF  = 2'b00,
    SRCH_FULL = 2'b01,
    SRCH_HI_A = 2'b10,
    SRCH_HI_B = 2'b11
  } srch_mode_e;

endpackage

// File: rtl/anm_ctl_reg.sv
`timescale 1ns/1ps
module anm_ctl_reg
  import anm_pkg::*;
#(
  parameter int LBL_W = 11,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [LBL_W-1:0] srch_name,
  output srch_mode_e       srch_mode
);

  localparam int NAME_EN = LBL_W;
  localparam int MODE_LO = LBL_W + 1;
  localparam int MODE_HI = LBL_W + 2;
  localparam int MODE_EN = LBL_W + 3;

  logic [LBL_W-1:0] name_q, name_d;
  srch_mode_e       mode_q, mode_d;
  logic             name_ld, mode_ld;

  assign name_ld = we && wdata[NAME_EN];
  assign mode_ld = we && wdata[MODE_EN];

  always_comb begin
    name_d = name_q;
    mode_d = mode_q;
    if (name_ld) name_d = wdata[LBL_W-1:0];
    if (mode_ld) mode_d = srch_mode_e'(wdata[MODE_HI:MODE_LO]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      name_q <= '0;
      mode_q <= SRCH_OFF;
    end else begin
      if (name_ld) name_q <= name_d;
      if (mode_ld) mode_q <= mode_d;
    end
  end

  assign srch_name = name_q;
  assign srch_mode = mode_q;

  // R2: name field follows its own enable
  a_r2_name_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && wdata[NAME_EN]) |=> $stable(srch_name));
  a_r2_name_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[NAME_EN]) |=> (srch_name == $past(wdata[LBL_W-1:0])));
  // R3: mode field follows its own enable
  a_r3_mode_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && wdata[MODE_EN]) |=> $stable(srch_mode));
  a_r3_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[MODE_EN]) |=> (srch_mode == $past(wdata[MODE_HI:MODE_LO])));

endmodule

// File: rtl/anm_compare.sv
`timescale 1ns/1ps
module anm_compare
  import anm_pkg::*;
#(
  parameter int LBL_W  = 11,
  parameter int HI_A_W = 8,
  parameter int HI_B_W = 4
) (
  input  logic             vld,
  input  logic [LBL_W-1:0] label,
  input  logic [LBL_W-1:0] srch_name,
  input  srch_mode_e       srch_mode,
  output logic             hit
);

  localparam int LO_A = LBL_W - HI_A_W;
  localparam int LO_B = LBL_W - HI_B_W;

  logic [LBL_W-1:0] mask_a, mask_b, mask_sel, diff;

  for (genvar i = 0; i < LBL_W; i++) begin : g_mask
    assign mask_a[i] = (i >= LO_A);
    assign mask_b[i] = (i >= LO_B);
  end

  always_comb begin
    unique case (srch_mode)
      SRCH_FULL: mask_sel = '1;
      SRCH_HI_A: mask_sel = mask_a;
      SRCH_HI_B: mask_sel = mask_b;
      default:   mask_sel = '0;
    endcase
  end

  assign diff = (label ^ srch_name) & mask_sel;
  assign hit  = vld && (srch_mode != SRCH_OFF) && (diff == '0);

endmodule

// File: rtl/anm_capture.sv
`timescale 1ns/1ps
module anm_capture #(
  parameter int LBL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  input  logic [LBL_W-1:0] label_in,
  output logic             flag,
  output logic [LBL_W-1:0] label_q
);

  logic             flag_q, flag_d;
  logic [LBL_W-1:0] lbl_q, lbl_d;

  always_comb begin
    flag_d = flag_q;
    lbl_d  = lbl_q;
    if (hit) begin
      flag_d = 1'b1;
      lbl_d  = label_in;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      lbl_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (hit) lbl_q <= lbl_d;
    end
  end

  assign flag    = flag_q;
  assign label_q = lbl_q;

  // R8 / R13: a hit always sets the flag and captures the label
  a_r8_flag_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag);
  a_r8_label_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (label_q == $past(label_in)));
  // R9: sticky until cleared, cleared when asked
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !hit) |=> !flag);
  // R10: label only moves on a hit
  a_r10_label_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(label_q));

endmodule

// File: rtl/assoc_name_search.sv
`timescale 1ns/1ps
module assoc_name_search
  import anm_pkg::*;
#(
  parameter int LBL_W  = 11,
  parameter int HI_A_W = 8,
  parameter int HI_B_W = 4,
  parameter int REG_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             name_vld,
  input  logic [LBL_W-1:0] name_label,
  input  logic             flag_clr,
  output logic [REG_W-1:0] name_rdata,
  output logic             match_irq
);

  localparam int MODE_LO = LBL_W + 1;
  localparam int MODE_HI = LBL_W + 2;

  logic [LBL_W-1:0] srch_name;
  srch_mode_e       srch_mode;
  logic             hit;
  logic             flag;
  logic [LBL_W-1:0] cap_label;

  anm_ctl_reg #(.LBL_W(LBL_W), .REG_W(REG_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctl_we),
    .wdata     (ctl_wdata),
    .srch_name (srch_name),
    .srch_mode (srch_mode)
  );

  anm_compare #(.LBL_W(LBL_W), .HI_A_W(HI_A_W), .HI_B_W(HI_B_W)) u_cmp (
    .vld       (name_vld),
    .label     (name_label),
    .srch_name (srch_name),
    .srch_mode (srch_mode),
    .hit       (hit)
  );

  anm_capture #(.LBL_W(LBL_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .clr      (flag_clr),
    .label_in (name_label),
    .flag     (flag),
    .label_q  (cap_label)
  );

  always_comb begin
    name_rdata                  = '0;
    name_rdata[REG_W-1]         = flag;
    name_rdata[MODE_HI:MODE_LO] = srch_mode;
    name_rdata[LBL_W-1:0]       = cap_label;
  end

  assign match_irq = flag;

  // R4: search off never hits
  a_r4_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_mode == SRCH_OFF) |-> !hit);
  // R11: no strobe, no hit
  a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !name_vld |-> !hit);
  // R8: interrupt tracks the read-back flag bit
  a_r8_irq_bit: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq == name_rdata[REG_W-1]);

endmodule

// File: tb/tb_assoc_name_search.sv
`timescale 1ns/1ps
module tb_assoc_name_search;

  logic        clk;
  logic        rst_n;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic        name_vld;
  logic [10:0] name_label;
  logic        flag_clr;
  logic [15:0] name_rdata;
  logic        match_irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // model state, derived from the requirements
  logic [10:0] m_name;
  logic [1:0]  m_mode;
  logic        m_flag;
  logic [10:0] m_label;

  assoc_name_search dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .name_vld(name_vld), .name_label(name_label), .flag_clr(flag_clr),
    .name_rdata(name_rdata), .match_irq(match_irq)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [10:0] mode_mask(logic [1:0] m);
    case (m)
      2'b01:   return 11'h7FF;
      2'b10:   return 11'h7F8;
      2'b11:   return 11'h780;
      default: return 11'h000;
    endcase
  endfunction

  task automatic check_out(string tag);
    logic [15:0] exp;
    exp = {m_flag, 1'b0, m_mode, 1'b0, m_label};
    checks++;
    if (name_rdata !== exp || match_irq !== m_flag) begin
      failures++;
      $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
               tag, name_rdata, match_irq, exp, m_flag);
    end
  endtask

  // one cycle of stimulus, model update, and check at the next falling edge
  task automatic step(input logic we, input logic [15:0] wd, input logic vld,
                      input logic [10:0] lbl, input logic clr, input string tag);
    logic hit;
    ctl_we = we; ctl_wdata = wd; name_vld = vld; name_label = lbl; flag_clr = clr;
    hit = vld && (m_mode != 2'b00) && (((lbl ^ m_name) & mode_mask(m_mode)) == 11'h0);
    if (hit) begin m_flag = 1'b1; m_label = lbl; end
    else if (clr) m_flag = 1'b0;
    if (we && wd[11]) m_name = wd[10:0];
    if (we && wd[14]) m_mode = wd[13:12];
    @(negedge clk);
    ctl_we = 0; name_vld = 0; flag_clr = 0;
    check_out(tag);
  endtask

  task automatic wr(input logic [15:0] wd, input string tag);
    step(1'b1, wd, 1'b0, 11'h0, 1'b0, tag);
  endtask

  task automatic strobe(input logic [10:0] lbl, input string tag);
    step(1'b0, 16'h0, 1'b1, lbl, 1'b0, tag);
  endtask

  task automatic clr(input string tag);
    step(1'b0, 16'h0, 1'b0, 11'h0, 1'b1, tag);
  endtask

  task automatic expect_flag(input logic e, input string tag);
    checks++;
    if (match_irq !== e) begin
      failures++;
      $display("FAIL %s: irq=%b expected %b", tag, match_irq, e);
    end
  endtask

  task automatic t_reset();
    check_out("R1 reset state");
  endtask

  task automatic t_mode_off();
    wr(16'h0800 | 16'h123, "R2 name load, mode stays off");
    strobe(11'h123, "R4 mode 00 equal label");
    expect_flag(1'b0, "R4 no match when off");
    wr(16'h4000 | 16'h0800 | 16'h000, "R3 explicit mode 00");
    strobe(11'h000, "R4 mode 00 zero label");
    expect_flag(1'b0, "R4 still no match");
  endtask

  task automatic t_full();
    wr(16'h4000 | 16'h1000 | 16'h0800 | 16'h5A5, "R3 mode 01 load");
    strobe(11'h5A4, "R5 differs in bit 0");
    expect_flag(1'b0, "R5 bit 0 mismatch rejected");
    strobe(11'h1A5, "R5 differs in bit 10");
    expect_flag(1'b0, "R5 bit 10 mismatch rejected");
    strobe(11'h5A5, "R8 full match");
    expect_flag(1'b1, "R8 flag after full match");
    clr("R9 clear");
    expect_flag(1'b0, "R9 flag cleared");
  endtask

  task automatic t_high8();
    wr(16'h4000 | 16'h2000 | 16'h07F, "R2 name kept, R3 mode 10");
    strobe(11'h5A5 ^ 11'h008, "R6 differs in bit 3");
    expect_flag(1'b0, "R6 bit 3 counts");
    strobe(11'h5A5 ^ 11'h007, "R6 differs only in low 3");
    expect_flag(1'b1, "R6 low 3 ignored");
    clr("R9 clear after R6");
  endtask

  task automatic t_high4();
    wr(16'h4000 | 16'h3000, "R3 mode 11");
    strobe(11'h5A5 ^ 11'h080, "R7 differs in bit 7");
    expect_flag(1'b0, "R7 bit 7 counts");
    strobe(11'h5A5 ^ 11'h07F, "R7 differs only in low 7");
    expect_flag(1'b1, "R7 low 7 ignored");
    clr("R9 clear after R7");
  endtask

  task automatic t_strobe_low();
    for (int i = 0; i < 3; i++)
      step(1'b0, 16'h0, 1'b0, 11'h5A5, 1'b0, "R11 label without strobe");
    expect_flag(1'b0, "R11 no flag without strobe");
  endtask

  task automatic t_sticky();
    wr(16'h4000 | 16'h1000 | 16'h0800 | 16'h2C3, "R3 mode 01 name 2C3");
    strobe(11'h2C3, "R8 first match");
    for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b0, 11'h0, 1'b0, "R9 flag held idle");
    strobe(11'h2C2, "R10 non-matching strobe keeps label");
    wr(16'h4000 | 16'h3000, "R3 widen to mode 11");
    strobe(11'h2FF, "R10 newer match replaces label");
    checks++;
    if (name_rdata[10:0] !== 11'h2FF) begin
      failures++;
      $display("FAIL R10: label=%h expected %h", name_rdata[10:0], 11'h2FF);
    end
    clr("R9 clear keeps label");
  endtask

  task automatic t_enables();
    wr(16'h8000 | 16'h2000 | 16'h555, "R3 no enables, bit 15 ignored");
    strobe(11'h2C3, "R2 old name still used");
    expect_flag(1'b1, "R2 name unchanged by disabled write");
    clr("R9 clear after R2");
  endtask

  task automatic t_same_cycle();
    step(1'b1, 16'h4000 | 16'h1000 | 16'h0800 | 16'h0AA, 1'b1, 11'h2C3, 1'b0,
         "R12 write and strobe together");
    expect_flag(1'b1, "R12 compare used old name");
    clr("R9 clear before R13");
    step(1'b0, 16'h0, 1'b1, 11'h0AA, 1'b1, "R13 match with clear");
    expect_flag(1'b1, "R13 match beats clear");
    checks++;
    if (name_rdata[10:0] !== 11'h0AA) begin
      failures++;
      $display("FAIL R13: label=%h expected %h", name_rdata[10:0], 11'h0AA);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ctl_we = 0; ctl_wdata = '0; name_vld = 0; name_label = '0; flag_clr = 0;
    m_name = '0; m_mode = 2'b00; m_flag = 0; m_label = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mode_off();
    t_full();
    t_high8();
    t_high4();
    t_strobe_low();
    t_sticky();
    t_enables();
    t_same_cycle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule